// File: doc/BRIEF.md
# ECC First Correctable-Error Capture

This block sits in the read-side ECC path of a memory controller and keeps a record of the first read that the decoder flagged as correctable. When the correctable-error strobe fires while capture is armed, the block stores two things from that read. It keeps the data word after correction and the raw check bits of the access. Capture is then disarmed. Later correctable errors leave the record untouched until the status-clear pulse from the ECC status logic arms capture again.

Software reads the record through a small register read port. A word address selects a 32-bit slice and the read data returns combinationally. The block has two configurations:

- The wide one (144-bit memory word, 128 data bits plus 16 check bits) implements four data slices.
- The narrow one (72-bit word, 64 data plus 8 check bits) implements only the two lower data slices. Its upper data slices read as zero.

Top module: `ecc_first_err_capture`

## Requirements
- R1: After reset every readable word returns zero and capture is armed, so the first strobe after reset is captured.
- R2: When `ce_strobe` is high and capture is armed, the corrected data word is stored. From the following cycle, address 0 returns data bits 31:0, address 1 returns bits 63:32, address 2 returns bits 95:64 and address 3 returns bits 127:96.
- R3: The check bits of that same access are stored in the same cycle. Address 4 returns them zero-extended to 32 bits.
- R4: While disarmed, further strobes change no readable word.
- R5: A `ce_status_clr` pulse without a captured strobe re-arms capture, and the next strobe is then stored.
- R6: A strobe and a clear in the same cycle while armed capture the new error and leave capture disarmed.
- R7: With `DQ_WIDTH` = 72, addresses 2 and 3 always read zero, and address 4 holds only the 8 check bits in bits 7:0.
- R8: With `DQ_WIDTH` = 144, all four data slices and the 16 check bits in bits 15:0 are stored and readable.
- R9: Addresses 5 to 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_data | input | DQ_WIDTH/9*8 | Corrected data word of the current read |
| corr_ecc | input | DQ_WIDTH/9 | Raw check bits of the current read |
| ce_strobe | input | 1 | Correctable error reported for the current read |
| ce_status_clr | input | 1 | Correctable-error status bit cleared; re-arms capture |
| rd_addr | input | 3 | Register word address |
| rd_data | output | 32 | Selected register word, combinational |

## Verification
If the armed flag is wrong, it shows at the read port on the cycle after the next strobe. A flag stuck set lets a second error overwrite the record. A flag stuck clear makes the first error after reset or after a clear go missing. A wrong slice selection or wrong width masking appears on the very next read of the affected address, because the read path has no storage of its own. The bench therefore sweeps every address on both configurations after every cycle, so any divergence is reported in the cycle it arises.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    localparam int MAX_DATA_W = 128;
    localparam int MAX_ECC_W  = 16;
    localparam int SLICE_W    = 32;
    localparam int ADDR_W     = 3;
    localparam int MAX_SLICES = MAX_DATA_W / SLICE_W;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA0 = 3'd0,
        RA_DATA1 = 3'd1,
        RA_DATA2 = 3'd2,
        RA_DATA3 = 3'd3,
        RA_CHECK = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [MAX_DATA_W-1:0] data;
        logic [MAX_ECC_W-1:0]  check;
    } cap_word_t;

    function automatic int data_bits(input int dq_w);
        return dq_w / 9 * 8;
    endfunction

    function automatic int check_bits(input int dq_w);
        return dq_w / 9;
    endfunction

endpackage

// File: rtl/ecc_cap_arm.sv
module ecc_cap_arm (
    input  logic clk,
    input  logic rst,
    input  logic err_stb,
    input  logic stat_clr,
    output logic cap_en,
    output logic armed
);

    assign cap_en = err_stb & armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end else if (cap_en) begin
            armed <= 1'b0;
        end else if (stat_clr) begin
            armed <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
    import ecc_cap_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int ECC_W  = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_en,
    input  cap_word_t cap_in,
    output cap_word_t held
);

    localparam int NSLICE = DATA_W / SLICE_W;

    for (genvar gs = 0; gs < MAX_SLICES; gs++) begin : g_slice
        if (gs < NSLICE) begin : g_impl
            logic [SLICE_W-1:0] slice_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slice_q <= '0;
                end else if (cap_en) begin
                    slice_q <= cap_in.data[gs*SLICE_W +: SLICE_W];
                end
            end
            assign held.data[gs*SLICE_W +: SLICE_W] = slice_q;
        end else begin : g_absent
            assign held.data[gs*SLICE_W +: SLICE_W] = '0;
        end
    end

    logic [ECC_W-1:0] check_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            check_q <= '0;
        end else if (cap_en) begin
            check_q <= cap_in.check[ECC_W-1:0];
        end
    end

    if (ECC_W < MAX_ECC_W) begin : g_check_pad
        assign held.check = {{(MAX_ECC_W-ECC_W){1'b0}}, check_q};
    end else begin : g_check_full
        assign held.check = check_q;
    end

endmodule

// File: rtl/ecc_cap_rdmux.sv
module ecc_cap_rdmux
    import ecc_cap_pkg::*;
(
    input  cap_word_t           held,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SLICE_W-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            RA_DATA0: rd_data = held.data[0*SLICE_W +: SLICE_W];
            RA_DATA1: rd_data = held.data[1*SLICE_W +: SLICE_W];
            RA_DATA2: rd_data = held.data[2*SLICE_W +: SLICE_W];
            RA_DATA3: rd_data = held.data[3*SLICE_W +: SLICE_W];
            RA_CHECK: rd_data = {{(SLICE_W-MAX_ECC_W){1'b0}}, held.check};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ecc_first_err_capture.sv
module ecc_first_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int DQ_WIDTH = 144,
    localparam int DATA_W  = data_bits(DQ_WIDTH),
    localparam int ECC_W   = check_bits(DQ_WIDTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   corr_data,
    input  logic [ECC_W-1:0]    corr_ecc,
    input  logic                ce_strobe,
    input  logic                ce_status_clr,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SLICE_W-1:0]  rd_data
);

    cap_word_t cap_in;
    cap_word_t held_q;
    logic      cap_en;
    logic      armed_q;

    assign cap_in.data  = MAX_DATA_W'(corr_data);
    assign cap_in.check = MAX_ECC_W'(corr_ecc);

    ecc_cap_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .err_stb  (ce_strobe),
        .stat_clr (ce_status_clr),
        .cap_en   (cap_en),
        .armed    (armed_q)
    );

    ecc_cap_store #(
        .DATA_W (DATA_W),
        .ECC_W  (ECC_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .cap_in (cap_in),
        .held   (held_q)
    );

    ecc_cap_rdmux u_rdmux (
        .held    (held_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk
    import ecc_cap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               err_stb,
    input logic               stat_clr,
    input logic               armed,
    input cap_word_t          held,
    input cap_word_t          cap_in,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [SLICE_W-1:0] rd_data
);

    p_armed_after_rst_r1: assert property (@(posedge clk)
        $past(rst) |-> armed);

    p_capture_data_r2: assert property (@(posedge clk) disable iff (rst)
        (err_stb && armed) |=> held.data == $past(cap_in.data));

    p_capture_check_r3: assert property (@(posedge clk) disable iff (rst)
        (err_stb && armed) |=> held.check == $past(cap_in.check));

    p_hold_when_disarmed_r4: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(held));

    p_rearm_on_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !(err_stb && armed)) |=> armed);

    p_capture_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (err_stb && armed) |=> !armed);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > 3'd4) |-> rd_data == '0);

endmodule

bind ecc_first_err_capture ecc_cap_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .err_stb  (ce_strobe),
    .stat_clr (ce_status_clr),
    .armed    (armed_q),
    .held     (held_q),
    .cap_in   (cap_in),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/tb_ecc_first_err_capture.sv
module tb_ecc_first_err_capture;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] data_w;
    logic [15:0]  ecc_w;
    logic         stb = 1'b0;
    logic         clr = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [31:0]  rdata_wide;
    logic [31:0]  rdata_narrow;

    int checks = 0;
    int fails  = 0;

    logic [127:0] exp_data;
    logic [15:0]  exp_ecc;
    bit           exp_armed;

    always #5 clk = ~clk;

    ecc_first_err_capture #(.DQ_WIDTH(144)) dut (
        .clk(clk), .rst(rst), .corr_data(data_w), .corr_ecc(ecc_w),
        .ce_strobe(stb), .ce_status_clr(clr), .rd_addr(addr), .rd_data(rdata_wide)
    );

    ecc_first_err_capture #(.DQ_WIDTH(72)) dut_narrow (
        .clk(clk), .rst(rst), .corr_data(data_w[63:0]), .corr_ecc(ecc_w[7:0]),
        .ce_strobe(stb), .ce_status_clr(clr), .rd_addr(addr), .rd_data(rdata_narrow)
    );

    function automatic logic [127:0] pat_data(input int k);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'h9E3779B9 * 32'(k*4 + i + 1);
        return v;
    endfunction

    function automatic logic [15:0] pat_ecc(input int k);
        return 16'(k * 16'h1357 + 16'h00A1);
    endfunction

    function automatic logic [31:0] exp_read(input bit wide, input int a);
        if (a < 4) begin
            if (!wide && a >= 2) return 32'h0;
            return exp_data[a*32 +: 32];
        end
        if (a == 4) return wide ? {16'h0, exp_ecc} : {24'h0, exp_ecc[7:0]};
        return 32'h0;
    endfunction

    task automatic check_one(input string tag, input bit wide, input int a, input logic [31:0] act);
        logic [31:0] e;
        string t;
        e = exp_read(wide, a);
        t = tag;
        if (a >= 5) t = "R9";
        else if (!wide && a >= 2) t = "R7";
        else if (wide && a >= 2) t = "R8";
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s cfg=%0s addr=%0d actual=%h expected=%h",
                     t, wide ? "144" : "72", a, act, e);
        end
    endtask

    task automatic sweep_reads(input string tag);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a);
            #1;
            check_one(tag, 1'b1, a, rdata_wide);
            check_one(tag, 1'b0, a, rdata_narrow);
        end
    endtask

    task automatic do_cycle(input bit s, input bit c, input int k, input string tag);
        stb    = s;
        clr    = c;
        data_w = pat_data(k);
        ecc_w  = pat_ecc(k);
        @(posedge clk);
        if (s && exp_armed) begin
            exp_data  = pat_data(k);
            exp_ecc   = pat_ecc(k);
            exp_armed = 1'b0;
        end else if (c) begin
            exp_armed = 1'b1;
        end
        @(negedge clk);
        stb = 1'b0;
        clr = 1'b0;
        sweep_reads(tag);
    endtask

    initial begin
        #(20000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        data_w    = '0;
        ecc_w     = '0;
        exp_data  = '0;
        exp_ecc   = '0;
        exp_armed = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state reads zero
        sweep_reads("R1");
        // R1, R2, R3: first strobe after reset is captured
        do_cycle(1'b1, 1'b0, 1, "R2");
        // R4: later strobes ignored
        do_cycle(1'b1, 1'b0, 2, "R4");
        do_cycle(1'b0, 1'b0, 9, "R4");
        do_cycle(1'b1, 1'b0, 3, "R4");
        // R5: clear re-arms, next strobe captured
        do_cycle(1'b0, 1'b1, 4, "R5");
        do_cycle(1'b0, 1'b0, 5, "R5");
        do_cycle(1'b1, 1'b0, 6, "R5");
        // strobe + clear while disarmed: not captured, re-armed
        do_cycle(1'b1, 1'b1, 7, "R5");
        // R6: strobe + clear while armed: captured, stays disarmed
        do_cycle(1'b1, 1'b1, 8, "R6");
        do_cycle(1'b1, 1'b0, 10, "R6");
        // R3, R8: sweep of mixed patterns
        for (int i = 0; i < 60; i++) begin
            do_cycle((i % 3) == 0, (i % 7) == 2, 20 + i, "R3");
        end
        // R1: reset mid-run returns to zero and armed
        rst = 1'b1;
        @(posedge clk);
        exp_data  = '0;
        exp_ecc   = '0;
        exp_armed = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sweep_reads("R1");
        do_cycle(1'b1, 1'b0, 99, "R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule